// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host a narrow data port into a network controller's local buffer memory. Software first loads a start address and a byte count. It then issues a stream of 1-, 2- or 4-byte reads or writes through a single strobe pair. Each access moves data at the current address, advances the address by the access size and lowers the count. When the count runs out, a sticky completion flag is raised for the interrupt logic.

Only two windows of the address space are backed by storage. The first is a small area at the bottom that holds the station address. The second is a buffer window starting at `WIN_LO`. Accesses that fall outside both windows read as all ones, and writes to them are dropped. The address wraps from the ring stop page back to the ring start page, so that a transfer can run through a circular receive buffer.

Top module: `rdma_port`

## Requirements
- R1: After reset, `cur_addr` and `cur_cnt` are 0 and `dma_done` is 0. The small area holds the following bytes: the station address (default 52 54 00 12 34 56) at bytes 0 to 5, most significant byte first; 0x57 at bytes 14 and 15; and 0xFF at every other byte below `PROM_BYTES`.
- R2: `acc_size` encodes the access width as follows: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. For 2- and 4-byte accesses, address bit 0 is taken as 0. The byte at the lowest address sits on `rdata[7:0]` and is taken from `wdata[7:0]` (little-endian). `rdata` lanes above the access width read 0.
- R3: A byte is backed when its address is below `PROM_BYTES`, or when it is at least `WIN_LO` and below `WIN_LO+WIN_BYTES`. A read of any other byte returns 0xFF for that byte, and a write to it is discarded.
- R4: `rdata` is valid in the same cycle as `acc_rd`. A write takes effect in memory at the next rising edge.
- R5: Each performed access advances `cur_addr` by the access size (1, 2 or 4) at the next rising edge.
- R6: On each performed access, the count changes as follows. If `cur_cnt` is greater than the size, it drops by the size. Otherwise it becomes 0 and `dma_done` is set.
- R7: A write strobe while `cur_cnt` is 0 is ignored. Memory, `cur_addr`, `cur_cnt` and `dma_done` are all left unchanged.
- R8: When the advanced address equals `ring_stop`×256, `cur_addr` is loaded with `ring_start`×256 instead.
- R9: `ld_addr` and `ld_cnt` load `cur_addr` and `cur_cnt` at the next edge, and take priority over an access update. `done_clr` clears `dma_done`, unless a completing access sets it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_addr | input | 1 | Load the address register |
| ld_addr_val | input | AW | Start address to load |
| ld_cnt | input | 1 | Load the byte counter |
| ld_cnt_val | input | AW | Byte count to load |
| ring_start | input | AW-8 | Ring start page |
| ring_stop | input | AW-8 | Ring stop page (exclusive) |
| acc_rd | input | 1 | Read strobe for one data port access |
| acc_wr | input | 1 | Write strobe; takes priority over `acc_rd` |
| acc_size | input | 2 | Access width code |
| wdata | input | 32 | Write data, little-endian |
| done_clr | input | 1 | Clear the completion flag |
| rdata | output | 32 | Read data, combinational |
| cur_addr | output | AW | Current address |
| cur_cnt | output | AW | Remaining byte count |
| dma_done | output | 1 | Sticky completion flag |

## Verification
Read data is combinational, so the bench checks `rdata` 1 ns after it drives a read strobe on a falling edge, within the same cycle. The address, the count, the completion flag and any memory write land at the following rising edge. The bench therefore checks them just after the next falling edge, once the strobe is released. A written byte is seen only through a later read. Loads and the flag clear follow the same one-edge timing as the access updates.

// File: rtl/rdma_port.sv
`timescale 1ns/1ps
module rdma_port #(
  parameter int          AW         = 16,
  parameter int          PROM_BYTES = 32,
  parameter int          WIN_LO     = 16384,
  parameter int          WIN_BYTES  = 2048,
  parameter logic [47:0] STATION    = 48'h5254_0012_3456,
  parameter logic [7:0]  SIG_BYTE   = 8'h57
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic [AW-1:0] ld_addr_val,
  input  logic          ld_cnt,
  input  logic [AW-1:0] ld_cnt_val,
  input  logic [AW-9:0] ring_start,
  input  logic [AW-9:0] ring_stop,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [1:0]    acc_size,
  input  logic [31:0]   wdata,
  input  logic          done_clr,
  output logic [31:0]   rdata,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_cnt,
  output logic          dma_done
);
  localparam int PAW    = $clog2(PROM_BYTES);
  localparam int WAW    = $clog2(WIN_BYTES);
  localparam int WIN_HI = WIN_LO + WIN_BYTES;

  logic [7:0]    prom [PROM_BYTES];
  logic [7:0]    win  [WIN_BYTES];
  logic [AW-1:0] addr_q, cnt_q, base, addr_inc, addr_nxt;
  logic [2:0]    nbytes;
  logic          done_q, do_wr, do_rd, step, last;
  logic [AW-1:0] lane_a [4];
  logic [AW-1:0] lane_o [4];
  logic [3:0]    lane_p, lane_w, lane_u;

  function automatic logic [7:0] init_byte(int k);
    if (k < 6)                return STATION[8*(5-k) +: 8];
    else if (k == 14 || k == 15) return SIG_BYTE;
    else                      return 8'hFF;
  endfunction

  assign nbytes   = (acc_size == 2'd0) ? 3'd1 : (acc_size == 2'd1) ? 3'd2 : 3'd4;
  assign base     = (acc_size == 2'd0) ? addr_q : {addr_q[AW-1:1], 1'b0};
  assign do_wr    = acc_wr && (cnt_q != '0);
  assign do_rd    = acc_rd && !acc_wr;
  assign step     = do_wr || do_rd;
  assign last     = cnt_q <= AW'(nbytes);
  assign addr_inc = addr_q + AW'(nbytes);
  assign addr_nxt = (addr_inc == {ring_stop, 8'h00}) ? {ring_start, 8'h00} : addr_inc;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign lane_a[i] = base + AW'(i);
    assign lane_o[i] = lane_a[i] - AW'(WIN_LO);
    assign lane_p[i] = 32'(lane_a[i]) < 32'(PROM_BYTES);
    assign lane_w[i] = (32'(lane_a[i]) >= 32'(WIN_LO)) && (32'(lane_a[i]) < 32'(WIN_HI));
    assign lane_u[i] = 3'(i) < nbytes;
    assign rdata[8*i +: 8] = !lane_u[i] ? 8'h00 :
                             lane_p[i]  ? prom[lane_a[i][PAW-1:0]] :
                             lane_w[i]  ? win[lane_o[i][WAW-1:0]] : 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < PROM_BYTES; k++) prom[k] <= init_byte(k);
    end else begin
      for (int i = 0; i < 4; i++)
        if (do_wr && lane_u[i] && lane_p[i]) prom[lane_a[i][PAW-1:0]] <= wdata[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (do_wr && lane_u[i] && lane_w[i]) win[lane_o[i][WAW-1:0]] <= wdata[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (ld_addr)   addr_q <= ld_addr_val;
      else if (step) addr_q <= addr_nxt;
      if (ld_cnt)    cnt_q <= ld_cnt_val;
      else if (step) cnt_q <= last ? '0 : cnt_q - AW'(nbytes);
      if (step && last) done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign dma_done = done_q;
endmodule

// File: rtl/rdma_port_chk.sv
`timescale 1ns/1ps
module rdma_port_chk #(
  parameter int AW         = 16,
  parameter int PROM_BYTES = 32,
  parameter int WIN_LO     = 16384,
  parameter int WIN_BYTES  = 2048
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_addr,
  input logic [AW-1:0] ld_addr_val,
  input logic          ld_cnt,
  input logic [AW-9:0] ring_start,
  input logic [AW-9:0] ring_stop,
  input logic          acc_rd,
  input logic          acc_wr,
  input logic [1:0]    acc_size,
  input logic          done_clr,
  input logic [31:0]   rdata,
  input logic [AW-1:0] cur_addr,
  input logic [AW-1:0] cur_cnt,
  input logic          dma_done
);
  logic [AW-1:0] sz;
  logic          any_go, go;
  assign sz     = (acc_size == 2'd0) ? AW'(1) : (acc_size == 2'd1) ? AW'(2) : AW'(4);
  assign any_go = (acc_rd && !acc_wr) || (acc_wr && cur_cnt != '0);
  assign go     = any_go && !ld_addr && !ld_cnt;

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go && (cur_addr + sz != {ring_stop, 8'h00}) |=> cur_addr == $past(cur_addr + sz));
  p_ring_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go && (cur_addr + sz == {ring_stop, 8'h00}) |=> cur_addr == {$past(ring_start), 8'h00});
  p_cnt_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go && (cur_cnt > sz) |=> cur_cnt == $past(cur_cnt - sz));
  p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go && (cur_cnt <= sz) |=> cur_cnt == '0 && dma_done);
  p_wr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && cur_cnt == '0 && !ld_addr && !ld_cnt |=> $stable(cur_addr) && cur_cnt == '0);
  p_oob_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && acc_size == 2'd0 && 32'(cur_addr) >= 32'(PROM_BYTES) &&
    (32'(cur_addr) < 32'(WIN_LO) || 32'(cur_addr) >= 32'(WIN_LO + WIN_BYTES)) |-> rdata == 32'h0000_00FF);
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_addr |=> cur_addr == $past(ld_addr_val));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr && !any_go |=> !dma_done);
endmodule

bind rdma_port rdma_port_chk #(.AW(AW), .PROM_BYTES(PROM_BYTES), .WIN_LO(WIN_LO), .WIN_BYTES(WIN_BYTES)) u_chk (.*);

// File: tb/test_rdma_port.sv
`timescale 1ns/1ps
module test_rdma_port;
  localparam int WLO = 16384;
  localparam int WB  = 2048;

  logic clk = 0, rst_n = 0;
  logic ld_addr = 0, ld_cnt = 0, acc_rd = 0, acc_wr = 0, done_clr = 0;
  logic [15:0] ld_addr_val = 0, ld_cnt_val = 0;
  logic [7:0]  ring_start = 8'd64, ring_stop = 8'd72;
  logic [1:0]  acc_size = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] cur_addr, cur_cnt;
  logic        dma_done;

  rdma_port i_rdma_port (.*);

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [7:0]  m_prom [32];
  logic [7:0]  m_win  [WB];
  logic [15:0] e_addr = 0, e_cnt = 0;
  logic        e_done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] m_rd(input logic [15:0] a);
    if (a < 16'd32) return m_prom[a[4:0]];
    if (a >= 16'(WLO) && a < 16'(WLO + WB)) return m_win[a - 16'(WLO)];
    return 8'hFF;
  endfunction

  task automatic m_wr(input logic [15:0] a, input logic [7:0] b);
    if (a < 16'd32) m_prom[a[4:0]] = b;
    else if (a >= 16'(WLO) && a < 16'(WLO + WB)) m_win[a - 16'(WLO)] = b;
  endtask

  task automatic chk_state(input string tag);
    chk(cur_addr == e_addr, {tag, " R5 R8 address"}, 32'(cur_addr), 32'(e_addr));
    chk(cur_cnt == e_cnt, {tag, " R6 R7 count"}, 32'(cur_cnt), 32'(e_cnt));
    chk(dma_done == e_done, {tag, " R6 done flag"}, 32'(dma_done), 32'(e_done));
  endtask

  task automatic do_load(input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    ld_addr = 1; ld_cnt = 1; ld_addr_val = a; ld_cnt_val = c;
    @(negedge clk);
    ld_addr = 0; ld_cnt = 0;
    e_addr = a; e_cnt = c;
    #1 chk_state("R9 load");
  endtask

  task automatic do_clr();
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0; e_done = 0;
    #1 chk(dma_done == 1'b0, "R9 clear", 32'(dma_done), 0);
  endtask

  task automatic do_acc(input bit wr, input logic [1:0] s, input logic [31:0] d, input string tag);
    int n;
    logic [15:0] b, nx;
    logic [31:0] ex;
    bit go;
    @(negedge clk);
    acc_rd = !wr; acc_wr = wr; acc_size = s; wdata = d;
    #1;
    n = nb(s);
    b = (s == 2'd0) ? e_addr : (e_addr & 16'hFFFE);
    if (!wr) begin
      ex = 0;
      for (int i = 0; i < n; i++) ex[8*i +: 8] = m_rd(b + 16'(i));
      chk(rdata == ex, {tag, " R2 R3 R4 read data"}, rdata, ex);
    end
    go = wr ? (e_cnt != 0) : 1'b1;
    if (wr && go) for (int i = 0; i < n; i++) m_wr(b + 16'(i), d[8*i +: 8]);
    if (go) begin
      nx = e_addr + 16'(n);
      if (nx == {ring_stop, 8'h00}) nx = {ring_start, 8'h00};
      e_addr = nx;
      if (32'(e_cnt) <= n) begin e_cnt = 0; e_done = 1; end
      else e_cnt = e_cnt - 16'(n);
    end
    @(negedge clk);
    acc_rd = 0; acc_wr = 0;
    #1 chk_state(tag);
  endtask

  initial begin
    void'($urandom(32'd4321));
    for (int k = 0; k < 32; k++) m_prom[k] = 8'hFF;
    m_prom[0] = 8'h52; m_prom[1] = 8'h54; m_prom[2] = 8'h00;
    m_prom[3] = 8'h12; m_prom[4] = 8'h34; m_prom[5] = 8'h56;
    m_prom[14] = 8'h57; m_prom[15] = 8'h57;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk_state("R1 reset");

    do_load(16'd0, 16'd32);
    for (int k = 0; k < 32; k++) do_acc(0, 2'd0, 0, "R1 prom");
    do_clr();

    do_load(16'(WLO), 16'(WB));
    for (int k = 0; k < WB / 4; k++) do_acc(1, 2'd2, $urandom, "R8 preload");
    chk(cur_addr == 16'(WLO), "R8 wrap after fill", 32'(cur_addr), WLO);
    do_clr();

    do_load(16'(WLO + 1), 16'd8);
    do_acc(1, 2'd1, 32'h1122_3344, "R2 odd 2-byte write");
    do_load(16'(WLO), 16'd4);
    for (int k = 0; k < 4; k++) do_acc(0, 2'd0, 0, "R2 byte order");

    do_load(16'd30, 16'd8);
    do_acc(1, 2'd2, 32'hCAFE_BEEF, "R3 prom edge write");
    do_load(16'd30, 16'd8);
    do_acc(0, 2'd3, 0, "R3 prom edge read");

    do_load(16'h1000, 16'd8);
    do_acc(0, 2'd1, 0, "R3 hole read");
    do_load(16'h9000, 16'd8);
    do_acc(1, 2'd2, 32'h0102_0304, "R3 hole write");
    do_load(16'h9000, 16'd8);
    do_acc(0, 2'd2, 0, "R3 hole readback");

    do_clr();
    do_load(16'(WLO + 16), 16'd0);
    do_acc(1, 2'd0, 32'h0000_00A5, "R7 zero count write");
    do_load(16'(WLO + 16), 16'd1);
    do_acc(0, 2'd0, 0, "R7 readback");

    do_load(16'(WLO + WB - 2), 16'd10);
    do_acc(0, 2'd1, 0, "R8 read wrap");
    do_clr();
    do_load(16'(WLO), 16'd3);
    do_acc(0, 2'd2, 0, "R6 short count");

    for (int k = 0; k < 400; k++) begin
      if ($urandom % 6 == 0) begin
        logic [15:0] a;
        case ($urandom % 5)
          0: a = 16'($urandom % 40);
          1: a = 16'(WLO - 4 + $urandom % 44);
          2: a = 16'(WLO + WB - 40 + $urandom % 44);
          3: a = 16'($urandom);
          default: a = 16'(WLO + $urandom % WB);
        endcase
        do_load(a, 16'($urandom % 25));
      end
      if ($urandom % 20 == 0) do_clr();
      do_acc(1'($urandom), 2'($urandom), $urandom, "R5 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule